// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every access a processor core makes on its internal bus and raises a break request when an access meets a programmed condition. It has two channels. Each channel holds a compare address with an exclusion mask, an address-space identifier and a condition byte. The condition byte selects instruction fetch and/or data access, read and/or write, an optional exact operand size, and, for instruction fetches, whether the break is taken before the instruction executes or only after it retires. The second channel can also require the data on the bus to equal a compare value under a data mask.

The two channels work independently. A hit on either one produces a one-cycle pulse on its own hit line and on the shared break line, and it sets a sticky per-channel flag that software clears by writing a one. Configuration arrives on static input ports that are held by surrounding register logic. An access is presented for one cycle with `acc_valid_i`, and retirement of an instruction is signalled with a `retire_i` pulse.

Top module: `bus_break_cmp`

## Requirements
- R1: An address bit whose mask bit is 1 is left out of the address compare. All other address bits must equal the channel base.
- R2: A channel hits only when `acc_asid_i` equals that channel's identifier.
- R3: The condition byte uses these bits. Bit 0 enables fetches and bit 1 enables data accesses, and the access kind must be enabled. Bit 2 enables reads and bit 3 enables writes, and the direction must be enabled. If both kinds or both directions are disabled, the channel never hits.
- R4: When condition bit 4 is 0, size takes no part in the match. The compare then ignores address bit 0 for a word access (size 1) and address bits 1:0 for a longword access (size 2 or 3). A byte access (size 0) compares every unmasked bit.
- R5: When condition bit 4 is 1, the access size must equal condition bits 6:5, and no low address bits are ignored beyond the mask.
- R6: When `b_dcmp_en_i` is 1, channel B also requires `((acc_data_i ^ b_data_i) & ~b_dmask_i)` to be zero over bits 7:0 for a byte access, bits 15:0 for a word access and all bits for a longword access.
- R7: A matching data access, or a matching fetch with condition bit 7 at 0, pulses the channel's `hit_o` bit for exactly the one cycle after the clock edge that sampled the access.
- R8: A matching fetch with condition bit 7 at 1 is held pending and produces no hit. The hit pulses in the cycle after the next edge with `retire_i` high. A deferred match that arrives together with a retire stays pending for the following retire.
- R9: Channels are independent. `brk_o` is high in every cycle in which either `hit_o` bit is high.
- R10: `flag_o[i]` is set when `hit_o[i]` rises. It stays set until an edge where `flag_clr_i[i]` is 1. If a hit and a clear occur at the same edge, the flag stays set.
- R11: While `rst_ni` is low, all outputs are 0 and any pending deferred break is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_addr_i | input | AW | Access address |
| acc_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 longword |
| acc_asid_i | input | ASW | Current address-space identifier |
| acc_data_i | input | DW | Data on the bus |
| retire_i | input | 1 | Instruction completion pulse |
| a_addr_i | input | AW | Channel A base address |
| a_amask_i | input | AW | Channel A address exclusion mask |
| a_asid_i | input | ASW | Channel A identifier |
| a_cond_i | input | 8 | Channel A condition byte |
| b_addr_i | input | AW | Channel B base address |
| b_amask_i | input | AW | Channel B address exclusion mask |
| b_asid_i | input | ASW | Channel B identifier |
| b_cond_i | input | 8 | Channel B condition byte |
| b_dcmp_en_i | input | 1 | Channel B data compare enable |
| b_data_i | input | DW | Channel B data compare value |
| b_dmask_i | input | DW | Channel B data exclusion mask |
| flag_clr_i | input | 2 | Write-one-to-clear for the flags |
| hit_o | output | 2 | Per-channel break pulse (bit 0 = A) |
| flag_o | output | 2 | Sticky per-channel match flags |
| brk_o | output | 1 | Combined break request |

## Verification
The assertions assume that the condition bytes stay constant while an access is in flight and while a deferred fetch break is pending. Under that assumption, a cycle with a disabled condition can be tied to the hit one cycle later. They also assume that a hit can only follow a cycle with a valid access or a retire. The bench changes configuration only between sweeps, at points where no deferred break is outstanding, and it clears any pending break through reset before switching modes. The sweeps cover address windows around each programmed range, every size and direction combination, all identifier values, all 128 condition codes without the after-execution bit, and data values whose upper bytes carry junk.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       after;
    logic [1:0] size;
    logic       size_chk;
    logic       wr_en;
    logic       rd_en;
    logic       data_en;
    logic       fetch_en;
  } cond_t;

  localparam int unsigned COND_W = $bits(cond_t);

  // low address bits an access of this size spans
  function automatic logic [1:0] span_bits(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: span_bits = 2'b00;
      SZ_WORD: span_bits = 2'b01;
      default: span_bits = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/bbc_chan_match.sv
module bbc_chan_match
  import bbc_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned ASW      = 8,
  parameter bit          HAS_DATA = 1'b0
) (
  input  logic              acc_valid_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic              acc_fetch_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic [ASW-1:0]    acc_asid_i,
  input  logic [DW-1:0]     acc_data_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     amask_i,
  input  logic [ASW-1:0]    asid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              dcmp_en_i,
  input  logic [DW-1:0]     dval_i,
  input  logic [DW-1:0]     dmask_i,
  output logic              hit_o,
  output logic              defer_o
);
  localparam logic [DW-1:0] BYTE_M = {{(DW-8){1'b0}}, 8'hFF};
  localparam logic [DW-1:0] WORD_M = {{(DW-16){1'b0}}, 16'hFFFF};

  cond_t         cond;
  logic [AW-1:0] addr_ign;
  logic          addr_ok, asid_ok, kind_ok, dir_ok, size_ok, data_ok;

  assign cond     = cond_t'(cond_i);
  assign addr_ign = amask_i | {{(AW-2){1'b0}},
                     (cond.size_chk ? 2'b00 : span_bits(acc_size_i))};
  assign addr_ok  = ((acc_addr_i ^ base_i) & ~addr_ign) == '0;
  assign asid_ok  = acc_asid_i == asid_i;
  assign kind_ok  = acc_fetch_i ? cond.fetch_en : cond.data_en;
  assign dir_ok   = acc_write_i ? cond.wr_en : cond.rd_en;
  assign size_ok  = !cond.size_chk || (acc_size_i == cond.size);

  if (HAS_DATA) begin : g_data
    logic [DW-1:0] width_m;
    always_comb begin
      case (acc_size_e'(acc_size_i))
        SZ_BYTE: width_m = BYTE_M;
        SZ_WORD: width_m = WORD_M;
        default: width_m = '1;
      endcase
    end
    assign data_ok = !dcmp_en_i ||
                     (((acc_data_i ^ dval_i) & ~dmask_i & width_m) == '0);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{dcmp_en_i, dval_i, dmask_i, acc_data_i};
    assign data_ok     = 1'b1;
  end

  assign hit_o   = acc_valid_i & addr_ok & asid_ok & kind_ok & dir_ok
                 & size_ok & data_ok;
  assign defer_o = acc_fetch_i & cond.after;
endmodule

// File: rtl/bbc_chan_ctrl.sv
module bbc_chan_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic defer_i,
  input  logic retire_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_o
);
  logic pend_q, hit_q, flag_q, fire;

  assign fire = (hit_i & ~defer_i) | (pend_q & retire_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q  <= fire;
      flag_q <= fire | (flag_q & ~clr_i);
      // new deferred match outranks the retire that drains the old one
      if (hit_i && defer_i)  pend_q <= 1'b1;
      else if (retire_i)     pend_q <= 1'b0;
    end
  end

  assign hit_o  = hit_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
  import bbc_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned ASW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_valid_i,
  input  logic [AW-1:0]   acc_addr_i,
  input  logic            acc_fetch_i,
  input  logic            acc_write_i,
  input  logic [1:0]      acc_size_i,
  input  logic [ASW-1:0]  acc_asid_i,
  input  logic [DW-1:0]   acc_data_i,
  input  logic            retire_i,
  input  logic [AW-1:0]   a_addr_i,
  input  logic [AW-1:0]   a_amask_i,
  input  logic [ASW-1:0]  a_asid_i,
  input  logic [7:0]      a_cond_i,
  input  logic [AW-1:0]   b_addr_i,
  input  logic [AW-1:0]   b_amask_i,
  input  logic [ASW-1:0]  b_asid_i,
  input  logic [7:0]      b_cond_i,
  input  logic            b_dcmp_en_i,
  input  logic [DW-1:0]   b_data_i,
  input  logic [DW-1:0]   b_dmask_i,
  input  logic [1:0]      flag_clr_i,
  output logic [1:0]      hit_o,
  output logic [1:0]      flag_o,
  output logic            brk_o
);
  localparam int unsigned NCH     = 2;
  localparam int unsigned DATA_CH = 1;

  logic [AW-1:0]     base_w  [NCH];
  logic [AW-1:0]     amask_w [NCH];
  logic [ASW-1:0]    asid_w  [NCH];
  logic [COND_W-1:0] cond_w  [NCH];
  logic              dcmp_w  [NCH];
  logic [DW-1:0]     dval_w  [NCH];
  logic [DW-1:0]     dmask_w [NCH];

  assign base_w[0]  = a_addr_i;
  assign amask_w[0] = a_amask_i;
  assign asid_w[0]  = a_asid_i;
  assign cond_w[0]  = a_cond_i;
  assign dcmp_w[0]  = 1'b0;
  assign dval_w[0]  = '0;
  assign dmask_w[0] = '0;

  assign base_w[1]  = b_addr_i;
  assign amask_w[1] = b_amask_i;
  assign asid_w[1]  = b_asid_i;
  assign cond_w[1]  = b_cond_i;
  assign dcmp_w[1]  = b_dcmp_en_i;
  assign dval_w[1]  = b_data_i;
  assign dmask_w[1] = b_dmask_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic m_hit, m_defer;

    bbc_chan_match #(
      .AW(AW), .DW(DW), .ASW(ASW), .HAS_DATA(g == DATA_CH)
    ) u_match (
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_fetch_i (acc_fetch_i),
      .acc_write_i (acc_write_i),
      .acc_size_i  (acc_size_i),
      .acc_asid_i  (acc_asid_i),
      .acc_data_i  (acc_data_i),
      .base_i      (base_w[g]),
      .amask_i     (amask_w[g]),
      .asid_i      (asid_w[g]),
      .cond_i      (cond_w[g]),
      .dcmp_en_i   (dcmp_w[g]),
      .dval_i      (dval_w[g]),
      .dmask_i     (dmask_w[g]),
      .hit_o       (m_hit),
      .defer_o     (m_defer)
    );

    bbc_chan_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (m_hit),
      .defer_i  (m_defer),
      .retire_i (retire_i),
      .clr_i    (flag_clr_i[g]),
      .hit_o    (hit_o[g]),
      .flag_o   (flag_o[g])
    );
  end

  assign brk_o = |hit_o;
endmodule

// File: rtl/bus_break_cmp_chk.sv
module bus_break_cmp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_valid_i,
  input logic       retire_i,
  input logic [7:0] a_cond_i,
  input logic [7:0] b_cond_i,
  input logic [1:0] flag_clr_i,
  input logic [1:0] hit_o,
  input logic [1:0] flag_o
);
  // R7
  hit_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_o) |-> $past(acc_valid_i || retire_i));

  // R3
  a_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_cond_i[1:0] == 2'b00 || a_cond_i[3:2] == 2'b00) |=> !hit_o[0]);

  // R3
  b_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_cond_i[1:0] == 2'b00 || b_cond_i[3:2] == 2'b00) |=> !hit_o[1]);

  for (genvar i = 0; i < 2; i++) begin : g_flag
    // R10
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !flag_clr_i[i]) |=> flag_o[i]);

    // R10
    flag_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[i] |-> flag_o[i]);

    // R10
    flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> hit_o[i]);
  end
endmodule

bind bus_break_cmp bus_break_cmp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .retire_i    (retire_i),
  .a_cond_i    (a_cond_i),
  .b_cond_i    (b_cond_i),
  .flag_clr_i  (flag_clr_i),
  .hit_o       (hit_o),
  .flag_o      (flag_o)
);

// File: tb/bus_break_cmp_test.sv
`timescale 1ns/1ps
module bus_break_cmp_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_fetch_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [1:0]  acc_size_i = '0;
  logic [7:0]  acc_asid_i = '0;
  logic [31:0] acc_data_i = '0;
  logic        retire_i = 1'b0;
  logic [31:0] a_addr_i = '0, a_amask_i = '0;
  logic [7:0]  a_asid_i = '0, a_cond_i = '0;
  logic [31:0] b_addr_i = '0, b_amask_i = '0;
  logic [7:0]  b_asid_i = '0, b_cond_i = '0;
  logic        b_dcmp_en_i = 1'b0;
  logic [31:0] b_data_i = '0, b_dmask_i = '0;
  logic [1:0]  flag_clr_i = '0;
  logic [1:0]  hit_o, flag_o;
  logic        brk_o;

  int checks = 0, errors = 0;
  logic [1:0] exp_flag = '0;
  logic [1:0] pend = '0;

  always #4 clk_i = ~clk_i;

  bus_break_cmp uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Match model written from the requirements
  function automatic logic exp_chan(input int ch);
    logic [31:0] b, m, ign, wm;
    logic [7:0]  as, cd;
    logic        ok;
    if (ch == 0) begin b = a_addr_i; m = a_amask_i; as = a_asid_i; cd = a_cond_i; end
    else         begin b = b_addr_i; m = b_amask_i; as = b_asid_i; cd = b_cond_i; end
    ign = m;
    if (!cd[4]) ign[1:0] = ign[1:0] | (acc_size_i == 2'd0 ? 2'b00 :
                                        acc_size_i == 2'd1 ? 2'b01 : 2'b11);
    ok = (((acc_addr_i ^ b) & ~ign) == 32'd0);                    // R1 R4
    ok = ok && (acc_asid_i == as);                                // R2
    ok = ok && (acc_fetch_i ? cd[0] : cd[1]);                     // R3
    ok = ok && (acc_write_i ? cd[3] : cd[2]);                     // R3
    if (cd[4]) ok = ok && (acc_size_i == cd[6:5]);                // R5
    if (ch == 1 && b_dcmp_en_i) begin                             // R6
      wm = acc_size_i == 2'd0 ? 32'hFF : acc_size_i == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF;
      ok = ok && (((acc_data_i ^ b_data_i) & ~b_dmask_i & wm) == 32'd0);
    end
    return ok && acc_valid_i;
  endfunction

  // One cycle: called at a falling edge, checks at the next falling edge
  task automatic cyc(input logic v, input logic r, input logic [1:0] clr,
                     input logic [31:0] a, input logic [1:0] sz, input logic f,
                     input logic w, input logic [7:0] as, input logic [31:0] d,
                     input string req);
    logic [1:0] fire, drain;
    acc_valid_i = v; retire_i = r; flag_clr_i = clr;
    acc_addr_i = a; acc_size_i = sz; acc_fetch_i = f; acc_write_i = w;
    acc_asid_i = as; acc_data_i = d;
    drain = pend & {2{r}};
    pend  = pend & ~drain;
    for (int ch = 0; ch < 2; ch++) begin
      logic m, dfr;
      m   = exp_chan(ch);
      dfr = f && (ch == 0 ? a_cond_i[7] : b_cond_i[7]);
      fire[ch] = (m && !dfr) || drain[ch];
      if (m && dfr) pend[ch] = 1'b1;
    end
    exp_flag = fire | (exp_flag & ~clr);
    @(negedge clk_i);
    acc_valid_i = 1'b0; retire_i = 1'b0; flag_clr_i = '0;
    chk(req, 32'(hit_o), 32'(fire));
    chk("R9", 32'(brk_o), 32'(|fire));
    chk("R10", 32'(flag_o), 32'(exp_flag));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R11 hit", 32'(hit_o), 0);
    chk("R11 flag", 32'(flag_o), 0);
    chk("R11 brk", 32'(brk_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pend = '0; exp_flag = '0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R1 R4 R7: two windows, fetch, word size, both identifiers
    a_addr_i = 32'h8404; a_amask_i = 32'hFFF; a_asid_i = 8'h80; a_cond_i = 8'h05;
    b_addr_i = 32'h8010; b_amask_i = 32'h006; b_asid_i = 8'h70; b_cond_i = 8'h05;
    for (int x = 32'h7F00; x < 32'h9100; x += 2)
      for (int s = 0; s < 2; s++)
        cyc(1, 0, 0, 32'(x), 2'd1, 1, 0, s ? 8'h70 : 8'h80, 0, "R1");

    // R2: identifier sweep at an address inside both windows
    for (int i = 0; i < 256; i++)
      cyc(1, 0, 0, 32'h8012, 2'd1, 1, 0, 8'(i), 0, "R2");

    // R4 R5: size coverage around 0x123456, zero mask
    b_cond_i = 8'h00;
    a_addr_i = 32'h123456; a_amask_i = 0;
    for (int c = 0; c < 2; c++) begin
      a_cond_i = c ? 8'h36 : 8'h06;
      for (int x = 32'h123450; x < 32'h12345C; x++)
        for (int sz = 0; sz < 3; sz++)
          for (int fw = 0; fw < 4; fw++)
            cyc(1, 0, 0, 32'(x), 2'(sz), fw[1], fw[0], 8'h80, 0, c ? "R5" : "R4");
    end

    // R3: every condition code without deferral
    a_addr_i = 32'h8404; a_amask_i = 32'hFFF;
    for (int c = 0; c < 128; c++) begin
      a_cond_i = 8'(c);
      for (int fw = 0; fw < 4; fw++)
        for (int sz = 0; sz < 3; sz++)
          cyc(1, 0, 0, 32'h8406, 2'(sz), fw[1], fw[0], 8'h80, 0, "R3");
    end
    a_cond_i = 8'h00;

    // R6: word write data compare within 0xABC00-0xABCFF
    b_addr_i = 32'hABCDE; b_amask_i = 32'hFF; b_asid_i = 8'h70; b_cond_i = 8'h3A;
    b_dcmp_en_i = 1; b_data_i = 32'hA512; b_dmask_i = 0;
    for (int x = 32'hABB00; x < 32'hABE00; x += 4)
      cyc(1, 0, 0, 32'(x), 2'd1, 0, 1, 8'h70, 32'h5A5A_A512, "R6");
    for (int i = 0; i < 256; i++)
      cyc(1, 0, 0, 32'hABC10, 2'd1, 0, 1, 8'h70, {16'(i * 37), 8'hA5, 8'(i)}, "R6");
    b_dmask_i = 32'hF;
    for (int i = 0; i < 64; i++)
      cyc(1, 0, 0, 32'hABC10, 2'd1, 0, 1, 8'h70, {24'h77A5, 8'(i)}, "R6");
    b_cond_i = 8'h0A; b_data_i = 32'h12; b_dmask_i = 0;
    for (int i = 0; i < 256; i++)
      for (int sz = 0; sz < 3; sz++)
        cyc(1, 0, 0, 32'hABC10, 2'(sz), 0, 1, 8'h70, {24'(i * 32'h10101), 8'(i)}, "R6");
    b_dcmp_en_i = 0;
    for (int i = 0; i < 16; i++)
      cyc(1, 0, 0, 32'hABC10, 2'd0, 0, 1, 8'h70, 32'(i * 3), "R6");
    b_cond_i = 8'h00;

    // R8: after-execution fetch breaks
    a_addr_i = 32'h8404; a_amask_i = 32'hFFF; a_cond_i = 8'h87;
    cyc(1, 0, 0, 32'h8404, 2'd1, 1, 0, 8'h80, 0, "R8 deferred");
    cyc(0, 0, 0, 0, 2'd0, 0, 0, 0, 0, "R8 idle");
    cyc(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, "R8 retire");
    cyc(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, "R8 empty retire");
    cyc(1, 0, 0, 32'h8404, 2'd2, 0, 0, 8'h80, 0, "R8 data not deferred");
    cyc(1, 0, 0, 32'h8404, 2'd1, 1, 0, 8'h80, 0, "R8 deferred");
    cyc(1, 1, 0, 32'h8500, 2'd1, 1, 0, 8'h80, 0, "R8 retire with new");
    cyc(0, 0, 0, 0, 2'd0, 0, 0, 0, 0, "R8 idle");
    cyc(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, "R8 second retire");
    cyc(1, 0, 0, 32'h8404, 2'd1, 1, 0, 8'h80, 0, "R8 deferred");

    // R11: reset discards the pending break
    do_reset();
    cyc(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, "R11 retire after reset");

    // R10: clear, and set winning over clear
    a_cond_i = 8'h05; b_addr_i = 32'h8010; b_amask_i = 32'h006; b_cond_i = 8'h05;
    cyc(1, 0, 0, 32'h8010, 2'd1, 1, 0, 8'h80, 0, "R10 set A");
    b_asid_i = 8'h80;
    cyc(1, 0, 0, 32'h8010, 2'd1, 1, 0, 8'h80, 0, "R10 set both");
    cyc(0, 0, 2'b01, 0, 2'd0, 0, 0, 0, 0, "R10 clear A");
    cyc(0, 0, 0, 0, 2'd0, 0, 0, 0, 0, "R10 hold");
    cyc(1, 0, 2'b11, 32'h8404, 2'd1, 1, 0, 8'h80, 0, "R10 set wins");
    cyc(0, 0, 2'b11, 0, 2'd0, 0, 0, 0, 0, "R10 clear all");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule